// File: doc/BRIEF.md
# CPU Clock Source and Low-Power Controller

This block chooses which clock drives the CPU and runs its two low-power states. The CPU clock is produced as a one-cycle enable (`cpu_clk_en`). It is taken from one of four sources: the main oscillator tick halved, the main oscillator tick divided by eight, the on-chip ring oscillator tick, or every main oscillator tick. The halved and divided-by-eight enables come from a free-running counter that advances on each main tick while the main oscillator is enabled. Software writes a small configuration word through a write strobe. The word holds the source code, one enable bit per oscillator and a stop-lock bit. Illegal source changes are refused.

The power state machine has four states. RUN is normal operation. WAIT halts the CPU and keeps only the selected source's oscillator alive. STOP halts the CPU and turns off both oscillators. STAB is entered after STOP while the restarted oscillator settles. Its transitions are: RUN to STOP on a permitted stop strobe, RUN to WAIT on a wait strobe, WAIT to RUN on an interrupt, STOP to STAB on an interrupt, and STAB to RUN when the external stabilization timer reports done. On the STOP-to-STAB move a one-cycle start pulse is sent to that timer. A stop strobe that is not permitted leaves the block in RUN.

Top module: `cpuclk_pwr_ctrl`

## Requirements
- R1: After reset the source code is 10 (ring oscillator), both oscillator enables are high, and `cpu_halt` and `stab_start` are low.
- R2: In RUN, `cpu_clk_en` is high on every second enabled main tick for code 00, on every eighth enabled main tick for code 01, on each enabled ring tick for code 10, and on every enabled main tick for code 11.
- R3: A write of source code 11 while `osc_is_rc` is 1 leaves the source code unchanged.
- R4: A written source code is taken only if the same write enables that source's oscillator; otherwise the old code is kept. The oscillator feeding the resulting source stays enabled even if the write clears its bit.
- R5: A stop strobe is ignored while the source code is 10 or while `adc_busy` is 1.
- R6: A stop strobe is ignored while `osd_en` is 1 or while the stop-lock bit is 1.
- R7: A permitted stop strobe moves to STOP on the next edge: `cpu_halt` goes high, both oscillator enables and `cpu_clk_en` go low. Stop takes priority over a simultaneous wait strobe.
- R8: A wait strobe in RUN moves to WAIT: `cpu_halt` goes high and `cpu_clk_en` goes low. Only the oscillator feeding the selected source stays enabled.
- R9: An interrupt in WAIT returns to RUN on the next edge, with the configured oscillator enables restored.
- R10: An interrupt in STOP re-enables the configured oscillators and raises `stab_start` for exactly one cycle. `cpu_halt` stays high until `stab_done` is seen.
- R11: Configuration writes made while `cpu_halt` is high have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_src | input | 2 | Source code written: 00 main/2, 01 main/8, 10 ring, 11 main/1 |
| cfg_main_on | input | 1 | Main oscillator enable bit written |
| cfg_ring_on | input | 1 | Ring oscillator enable bit written |
| cfg_stop_lock | input | 1 | Stop-lock bit written; 1 forbids stop |
| osc_is_rc | input | 1 | Strap: 1 means RC main oscillator, 0 ceramic |
| stop_req | input | 1 | Stop instruction strobe |
| wait_req | input | 1 | Wait instruction strobe |
| irq | input | 1 | Interrupt request |
| adc_busy | input | 1 | A-D conversion in progress |
| osd_en | input | 1 | Oscillation-stop detection enabled |
| stab_done | input | 1 | Stabilization timer finished |
| main_tick | input | 1 | Main oscillator tick enable |
| ring_tick | input | 1 | Ring oscillator tick enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| main_osc_en | output | 1 | Main oscillator enable |
| ring_osc_en | output | 1 | Ring oscillator enable |
| cpu_halt | output | 1 | CPU halted |
| stab_start | output | 1 | One-cycle start pulse for the stabilization timer |

## Verification
A wrong power state shows on `cpu_halt` and the two oscillator enables one edge after the strobe or interrupt that caused it, because all three decode straight from the state register. A wrong source code shows as the wrong `cpu_clk_en` pulse rate. That error only appears over a window of eight main ticks, so the bench counts pulses over such windows after each configuration write. A counter phase error is invisible at the ports except through those rates.

// File: rtl/cpuclk_pkg.sv
package cpuclk_pkg;

    typedef enum logic [1:0] {
        SRC_MAIN_D2 = 2'b00,
        SRC_MAIN_D8 = 2'b01,
        SRC_RING    = 2'b10,
        SRC_MAIN_X1 = 2'b11
    } clk_src_e;

    typedef enum logic [1:0] {
        PS_RUN,
        PS_WAIT,
        PS_STOP,
        PS_STAB
    } pwr_state_e;

    typedef struct packed {
        clk_src_e src;
        logic     main_on;
        logic     ring_on;
        logic     stop_lock;
    } clk_cfg_t;

endpackage

// File: rtl/cpuclk_div.sv
module cpuclk_div #(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic main_pulse,
    output logic fast_pulse,
    output logic slow_pulse
);
    localparam int CNT_W = $clog2(SLOW_DIV);
    localparam logic [CNT_W-1:0] FAST_MASK = CNT_W'(FAST_DIV - 1);
    localparam logic [CNT_W-1:0] SLOW_MASK = CNT_W'(SLOW_DIV - 1);

    logic [CNT_W-1:0] cnt;

    // Free-running phase counter, advanced only by enabled main ticks.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (main_pulse)
            cnt <= cnt + CNT_W'(1);
    end

    assign fast_pulse = main_pulse && ((cnt & FAST_MASK) == FAST_MASK);
    assign slow_pulse = main_pulse && (cnt == SLOW_MASK);

endmodule

// File: rtl/cpuclk_cfg.sv
module cpuclk_cfg
    import cpuclk_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     we,
    input  clk_cfg_t wr,
    input  logic     allow,
    input  logic     osc_is_rc,
    output clk_cfg_t cfg
);
    clk_cfg_t nxt;
    logic     src_ok;

    always_comb begin
        nxt    = cfg;
        src_ok = 1'b0;
        if (we && allow) begin
            nxt.main_on   = wr.main_on;
            nxt.ring_on   = wr.ring_on;
            nxt.stop_lock = wr.stop_lock;
            unique case (wr.src)
                SRC_RING:    src_ok = wr.ring_on;
                SRC_MAIN_X1: src_ok = wr.main_on && !osc_is_rc;
                default:     src_ok = wr.main_on;
            endcase
            if (src_ok)
                nxt.src = wr.src;
            // The oscillator feeding the resulting source must stay on.
            if (nxt.src == SRC_RING)
                nxt.ring_on = 1'b1;
            else
                nxt.main_on = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg.src       <= SRC_RING;
            cfg.main_on   <= 1'b1;
            cfg.ring_on   <= 1'b1;
            cfg.stop_lock <= 1'b0;
        end else begin
            cfg <= nxt;
        end
    end

    // R3: undivided main source never appears on an RC part
    a_r3_no_x1_on_rc: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.src == SRC_MAIN_X1 && $past(cfg.src) != SRC_MAIN_X1) |-> !$past(osc_is_rc));

    // R11: configuration frozen while halted
    a_r11_frozen_halted: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(allow) |-> $stable(cfg));

endmodule

// File: rtl/cpuclk_pwr_fsm.sv
module cpuclk_pwr_fsm
    import cpuclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stop_req,
    input  logic       wait_req,
    input  logic       irq,
    input  logic       stab_done,
    input  logic       stop_ok,
    input  clk_src_e   src,
    input  logic       main_on,
    input  logic       ring_on,
    output pwr_state_e state,
    output logic       cpu_halt,
    output logic       main_osc_en,
    output logic       ring_osc_en,
    output logic       run_clk,
    output logic       stab_start
);
    pwr_state_e state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            PS_RUN: begin
                if (stop_req && stop_ok)
                    state_nxt = PS_STOP;
                else if (wait_req)
                    state_nxt = PS_WAIT;
            end
            PS_WAIT: if (irq)       state_nxt = PS_RUN;
            PS_STOP: if (irq)       state_nxt = PS_STAB;
            PS_STAB: if (stab_done) state_nxt = PS_RUN;
            default:                state_nxt = PS_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= PS_RUN;
            stab_start <= 1'b0;
        end else begin
            state      <= state_nxt;
            stab_start <= (state == PS_STOP) && irq;
        end
    end

    always_comb begin
        cpu_halt    = 1'b1;
        run_clk     = 1'b0;
        main_osc_en = main_on;
        ring_osc_en = ring_on;
        unique case (state)
            PS_RUN: begin
                cpu_halt = 1'b0;
                run_clk  = 1'b1;
            end
            PS_WAIT: begin
                main_osc_en = main_on && (src != SRC_RING);
                ring_osc_en = ring_on && (src == SRC_RING);
            end
            PS_STOP: begin
                main_osc_en = 1'b0;
                ring_osc_en = 1'b0;
            end
            default: ;
        endcase
    end

    // R5/R6: stop entered only when permitted
    a_r5_stop_entry_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_STOP && $past(state) == PS_RUN) |-> $past(stop_ok));

    // R9: wait left only through an interrupt
    a_r9_wait_exit_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RUN && $past(state) == PS_WAIT) |-> $past(irq));

    // R10: start pulse lasts one cycle
    a_r10_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        stab_start |=> !stab_start);

    // R10: settling ends only on the timer's done
    a_r10_stab_exit_done: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_RUN && $past(state) == PS_STAB) |-> $past(stab_done));

endmodule

// File: rtl/cpuclk_pwr_ctrl.sv
module cpuclk_pwr_ctrl
    import cpuclk_pkg::*;
#(
    parameter int FAST_DIV = 2,
    parameter int SLOW_DIV = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [1:0] cfg_src,
    input  logic       cfg_main_on,
    input  logic       cfg_ring_on,
    input  logic       cfg_stop_lock,
    input  logic       osc_is_rc,
    input  logic       stop_req,
    input  logic       wait_req,
    input  logic       irq,
    input  logic       adc_busy,
    input  logic       osd_en,
    input  logic       stab_done,
    input  logic       main_tick,
    input  logic       ring_tick,
    output logic       cpu_clk_en,
    output logic       main_osc_en,
    output logic       ring_osc_en,
    output logic       cpu_halt,
    output logic       stab_start
);
    clk_cfg_t   wr_word;
    clk_cfg_t   cfg;
    pwr_state_e state;
    logic       run_clk;
    logic       stop_ok;
    logic       main_pulse;
    logic       ring_pulse;
    logic       fast_pulse;
    logic       slow_pulse;
    logic       src_pulse;

    assign wr_word = '{src: clk_src_e'(cfg_src), main_on: cfg_main_on,
                       ring_on: cfg_ring_on, stop_lock: cfg_stop_lock};

    cpuclk_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wr        (wr_word),
        .allow     (!cpu_halt),
        .osc_is_rc (osc_is_rc),
        .cfg       (cfg)
    );

    assign stop_ok = !osd_en && !cfg.stop_lock && !adc_busy && (cfg.src != SRC_RING);

    cpuclk_pwr_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_req    (stop_req),
        .wait_req    (wait_req),
        .irq         (irq),
        .stab_done   (stab_done),
        .stop_ok     (stop_ok),
        .src         (cfg.src),
        .main_on     (cfg.main_on),
        .ring_on     (cfg.ring_on),
        .state       (state),
        .cpu_halt    (cpu_halt),
        .main_osc_en (main_osc_en),
        .ring_osc_en (ring_osc_en),
        .run_clk     (run_clk),
        .stab_start  (stab_start)
    );

    assign main_pulse = main_tick && main_osc_en;
    assign ring_pulse = ring_tick && ring_osc_en;

    cpuclk_div #(.FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .main_pulse (main_pulse),
        .fast_pulse (fast_pulse),
        .slow_pulse (slow_pulse)
    );

    always_comb begin
        unique case (cfg.src)
            SRC_MAIN_D2: src_pulse = fast_pulse;
            SRC_MAIN_D8: src_pulse = slow_pulse;
            SRC_RING:    src_pulse = ring_pulse;
            SRC_MAIN_X1: src_pulse = main_pulse;
            default:     src_pulse = 1'b0;
        endcase
    end

    assign cpu_clk_en = run_clk && src_pulse;

    // R7/R8: no CPU clock while halted
    a_r7_no_clk_halted: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> !cpu_clk_en);

    // R5: full shutdown never entered from the ring source or during conversion
    a_r5_stop_guard: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cpu_halt) && !main_osc_en && !ring_osc_en)
            |-> $past(cfg.src != SRC_RING && !adc_busy && !osd_en));

    // R8: in wait the selected source keeps its oscillator
    a_r8_wait_src_alive: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_WAIT) |-> ((cfg.src == SRC_RING) ? ring_osc_en : main_osc_en));

endmodule

// File: tb/tb_cpuclk_pwr_ctrl.sv
`timescale 1ns/100ps
module tb_cpuclk_pwr_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_src = 2'b00;
    logic       cfg_main_on = 1'b0;
    logic       cfg_ring_on = 1'b0;
    logic       cfg_stop_lock = 1'b0;
    logic       osc_is_rc = 1'b1;
    logic       stop_req = 1'b0;
    logic       wait_req = 1'b0;
    logic       irq = 1'b0;
    logic       adc_busy = 1'b0;
    logic       osd_en = 1'b0;
    logic       stab_done = 1'b0;
    logic       main_tick = 1'b0;
    logic       ring_tick = 1'b0;
    logic       cpu_clk_en, main_osc_en, ring_osc_en, cpu_halt, stab_start;

    cpuclk_pwr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_src(cfg_src),
        .cfg_main_on(cfg_main_on), .cfg_ring_on(cfg_ring_on),
        .cfg_stop_lock(cfg_stop_lock), .osc_is_rc(osc_is_rc),
        .stop_req(stop_req), .wait_req(wait_req), .irq(irq),
        .adc_busy(adc_busy), .osd_en(osd_en), .stab_done(stab_done),
        .main_tick(main_tick), .ring_tick(ring_tick),
        .cpu_clk_en(cpu_clk_en), .main_osc_en(main_osc_en),
        .ring_osc_en(ring_osc_en), .cpu_halt(cpu_halt), .stab_start(stab_start)
    );

    always #2.5 clk = ~clk;

    typedef struct {
        int          due;
        string       rq;
        logic [4:0]  ev;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pops every expectation due in this cycle and compares.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t it;
                logic [4:0] act;
                it  = q.pop_front();
                act = {cpu_clk_en, main_osc_en, ring_osc_en, cpu_halt, stab_start};
                n_chk++;
                if (act !== it.ev) begin
                    n_err++;
                    $display("FAIL %s cycle %0d: {clk_en,main,ring,halt,start} actual=%b expected=%b",
                             it.rq, cyc, act, it.ev);
                end
            end
        end
    end

    // Driver side: expectation for the sample after the next edge.
    task automatic expect_out(string rq, logic ce, logic me, logic re, logic h, logic ss);
        exp_t it;
        it.due = cyc + 1;
        it.rq  = rq;
        it.ev  = {ce, me, re, h, ss};
        q.push_back(it);
    endtask

    task automatic chk(string rq, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    task automatic write_cfg(logic [1:0] s, logic mo, logic ro, logic lk);
        @(negedge clk);
        cfg_we = 1'b1; cfg_src = s; cfg_main_on = mo; cfg_ring_on = ro; cfg_stop_lock = lk;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic count_en(int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
            if (cpu_clk_en) c++;
        end
        @(negedge clk);
    endtask

    task automatic pulse_stop();
        @(negedge clk);
        stop_req = 1'b1;
    endtask

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_out("R1 reset state", 0, 1, 1, 0, 0);

        // R2: ring source follows ring ticks
        @(negedge clk);
        ring_tick = 1'b1;
        expect_out("R2 ring tick passes", 1, 1, 1, 0, 0);
        @(negedge clk);
        ring_tick = 1'b0;

        // R5: stop refused on ring source
        stop_req = 1'b1;
        expect_out("R5 stop ignored on ring", 0, 1, 1, 0, 0);
        @(negedge clk);
        stop_req = 1'b0;

        // R4: move to main/2, ring turned off
        cfg_we = 1'b1; cfg_src = 2'b00; cfg_main_on = 1'b1; cfg_ring_on = 1'b0; cfg_stop_lock = 1'b0;
        expect_out("R4 main/2 accepted ring off", 0, 1, 0, 0, 0);
        @(negedge clk);
        cfg_we = 1'b0;
        main_tick = 1'b1;
        count_en(8, c);
        chk("R2 main/2 rate", c, 4);

        // R3: undivided main refused on RC part
        write_cfg(2'b11, 1'b1, 1'b0, 1'b0);
        count_en(8, c);
        chk("R3 x1 refused on rc", c, 4);
        osc_is_rc = 1'b0;
        write_cfg(2'b11, 1'b1, 1'b0, 1'b0);
        count_en(8, c);
        chk("R2 main/1 rate", c, 8);

        // R4: ring source refused when the write leaves ring off
        write_cfg(2'b10, 1'b1, 1'b0, 1'b0);
        count_en(8, c);
        chk("R4 ring refused without osc", c, 8);

        // R4: clearing main bit while main feeds CPU is overridden
        cfg_we = 1'b1; cfg_src = 2'b11; cfg_main_on = 1'b0; cfg_ring_on = 1'b0;
        expect_out("R4 main kept on", 1, 1, 0, 0, 0);
        @(negedge clk);
        cfg_we = 1'b0;
        write_cfg(2'b01, 1'b1, 1'b1, 1'b0);
        count_en(16, c);
        chk("R2 main/8 rate", c, 2);
        main_tick = 1'b0;

        // R5: stop refused during conversion
        adc_busy = 1'b1; stop_req = 1'b1;
        expect_out("R5 stop ignored adc busy", 0, 1, 1, 0, 0);
        @(negedge clk);
        adc_busy = 1'b0;
        osd_en = 1'b1;
        expect_out("R6 stop ignored osd on", 0, 1, 1, 0, 0);
        @(negedge clk);
        osd_en = 1'b0; stop_req = 1'b0;
        write_cfg(2'b01, 1'b1, 1'b1, 1'b1);
        stop_req = 1'b1;
        expect_out("R6 stop ignored lock set", 0, 1, 1, 0, 0);
        @(negedge clk);
        stop_req = 1'b0;
        write_cfg(2'b01, 1'b1, 1'b1, 1'b0);

        // R8: wait keeps main (source) only
        wait_req = 1'b1; main_tick = 1'b1;
        expect_out("R8 wait entered", 0, 1, 0, 1, 0);
        @(negedge clk);
        wait_req = 1'b0;
        cfg_we = 1'b1; cfg_src = 2'b00; cfg_main_on = 1'b1; cfg_ring_on = 1'b0; cfg_stop_lock = 1'b1;
        expect_out("R8 wait held", 0, 1, 0, 1, 0);
        @(negedge clk);
        cfg_we = 1'b0; main_tick = 1'b0;
        irq = 1'b1;
        expect_out("R9 wait left on irq", 0, 1, 1, 0, 0);
        @(negedge clk);
        irq = 1'b0;
        main_tick = 1'b1;
        count_en(16, c);
        chk("R11 write in wait ignored rate", c, 2);
        main_tick = 1'b0;

        // R7: stop wins over wait; R11 lock write was ignored
        stop_req = 1'b1; wait_req = 1'b1;
        expect_out("R7 stop entered", 0, 0, 0, 1, 0);
        @(negedge clk);
        stop_req = 1'b0; wait_req = 1'b0; main_tick = 1'b1;
        expect_out("R7 stop held no clock", 0, 0, 0, 1, 0);
        @(negedge clk);
        main_tick = 1'b0; irq = 1'b1;
        expect_out("R10 restart pulse", 0, 1, 1, 1, 1);
        @(negedge clk);
        irq = 1'b0;
        expect_out("R10 pulse single", 0, 1, 1, 1, 0);
        @(negedge clk);
        expect_out("R10 halt until done", 0, 1, 1, 1, 0);
        @(negedge clk);
        stab_done = 1'b1;
        expect_out("R10 released on done", 0, 1, 1, 0, 0);
        @(negedge clk);
        stab_done = 1'b0;
        repeat (3) @(negedge clk);

        chk("R1 scoreboard drained", q.size(), 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule